// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a cycle-level model of a byte-wide parallel NOR flash device holding a small internal array. A host drives a simple synchronous bus with an address, a write strobe with write data, and a read strobe. Bus writes are not stored directly. They are decoded as a multi-cycle command protocol. Two keyed unlock writes at fixed word offsets open a command slot, and the byte written into that slot selects one of several operations: program, erase setup, identification, or the unlock-bypass shortcut. Erase needs a second keyed pair before the final erase opcode.

The active command decides what a read returns. A read can return array bytes, identification bytes, a status byte whose bit 6 toggles on every read, or an entry of a small query table that describes the device geometry. Program and erase update the array at once. Erase then holds the device in a busy window for a parameterised number of clock cycles. During that window reads return status and writes are ignored. A read-only input blocks every change to the array but leaves the protocol running.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous active-low reset the device is in read mode with bypass off, every array byte reads 0xFF, and rd_data is 0x00.
- R2: A command is opened by 0xAA at offset UNLOCK0 and then 0x55 at offset UNLOCK1, and is issued by a command byte at UNLOCK0. The offset is addr[7:0]. Any other write at any of these steps returns the device to read mode and changes nothing.
- R3: The accepted command bytes are 0x20 (enter bypass), 0x80 (erase setup), 0x90 (identification) and 0xA0 (program). Any other byte aborts to read mode.
- R4: The write after 0xA0 programs that address with the AND of the old byte and the data, so bits can only be cleared. A data byte of 0xF0 here is programmed. It is not treated as an abort.
- R5: In every other state, a write of 0xF0 returns the device to read mode and clears bypass. This includes an erase busy window.
- R6: After 0x80 and a second 0xAA/0x55 pair, 0x30 at any address fills the sector holding that address with 0xFF. The sector is selected by addr[ADDR_W-1:SECT_W]. 0x10 at UNLOCK0 fills the whole array with 0xFF. 0x10 at any other offset aborts.
- R7: From the erase opcode until the busy window ends, reads return a status byte that starts at 0x00 and toggles bit 6 on each read. Writes other than 0xF0 are ignored. After SECT_BUSY cycles (sector) or CHIP_BUSY cycles (chip), the device returns to read mode, or to the command slot if bypass is on.
- R8: 0x20 in the command slot turns bypass on. In bypass mode the command slot accepts a byte at any address with no unlock pair, and a program returns to the command slot. Writing 0x00 right after 0x90 in bypass turns bypass off and returns to read mode.
- R9: In identification mode, offsets 0 and 1 read ID0 and ID1, and offset 2 reads 0x00. Offsets 0x0E and 0x0F read ID2 and ID3, or the array byte when that ID is 0xFF. All other offsets read the array.
- R10: 0x98 at offset 0x55 enters query mode from read mode or from identification mode. In query mode, offsets 0x10..0x12 read 0x51, 0x52, 0x59. Offset 0x27 reads ADDR_W. Offset 0x2D reads the sector count minus one. Offset 0x2F reads the sector size divided by 256. Offsets 0x52 and above read 0. Any write leaves query mode for read mode.
- R11: While ro is high, program and erase leave the array unchanged, but the command protocol and status behave as usual.
- R12: rd_data is updated one cycle after a cycle with rd_en high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 8 | Write data or command byte |
| ro | input | 1 | Blocks array modification when high |
| rd_data | output | 8 | Registered read data |

## Verification
If the phase counter or the latched command is wrong, the fault shows on the next read. A read meant for the array then returns status, an ID or a query byte instead, or the reverse. A phase that fails to fall back to read mode shows up one write later as a program or erase that should not have happened, and a later array read exposes it. The bench sweeps every address with a computed pattern. It then drives each abort path, and after every abort a stray data write must leave the array unchanged. A busy window that is too short or too long changes the value of the first read after the window's expected end.

// File: rtl/nor_seq_pkg.sv
// Shared command codes and sequencer phases for the NOR command sequencer.
// Assumes an 8-bit data bus; command codes equal the bus byte that selects them.
package nor_seq_pkg;
    typedef enum logic [7:0] {
        CMD_NONE  = 8'h00,
        CMD_CHIP  = 8'h10,
        CMD_SECT  = 8'h30,
        CMD_ERASE = 8'h80,
        CMD_ID    = 8'h90,
        CMD_CFI   = 8'h98,
        CMD_PROG  = 8'hA0
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_UNLK  = 3'd1,
        PH_CMD   = 3'd2,
        PH_ARG   = 3'd3,
        PH_UNLK2 = 3'd4,
        PH_SEL   = 3'd5,
        PH_BUSY  = 3'd6,
        PH_QUERY = 3'd7
    } phase_e;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] OP_BYPASS  = 8'h20;
    localparam logic [7:0] OP_ABORT   = 8'hF0;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BYPEXIT = 8'h00;
    localparam logic [7:0] QUERY_OFF  = 8'h55;
endpackage

// File: rtl/nor_seq_ctrl.sv
// Write-protocol decoder: phase counter, latched command, bypass flag,
// status byte and erase busy timer. Emits one-cycle program/erase pulses.
// Assumes wr_en and rd_en are not asserted in the same cycle; if they are,
// the write's effect on status wins.
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter logic [7:0] UNLOCK0   = 8'hAA,
    parameter logic [7:0] UNLOCK1   = 8'h55,
    parameter int         SECT_BUSY = 16,
    parameter int         CHIP_BUSY = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [7:0] off_i,
    input  logic [7:0] wdata_i,
    output cmd_e       cmd_o,
    output logic [7:0] status_o,
    output logic       prog_o,
    output logic       sect_o,
    output logic       chip_o
);
    localparam int CNT_W = $clog2(CHIP_BUSY + 1);

    phase_e            ph_q, n_ph;
    cmd_e              cmd_q, n_cmd;
    logic              byp_q, n_byp;
    logic [7:0]        stat_q, n_stat;
    logic [CNT_W-1:0]  cnt_q, n_cnt;
    logic              abort;
    logic              hit_query, hit_a, hit_b;

    assign hit_query = (off_i == QUERY_OFF) && (wdata_i == OP_QUERY);
    assign hit_a     = (off_i == UNLOCK0) && (wdata_i == KEY_A);
    assign hit_b     = (off_i == UNLOCK1) && (wdata_i == KEY_B);

    // Next-state decode: status toggle, busy countdown, then the write protocol.
    always_comb begin
        n_ph = ph_q; n_cmd = cmd_q; n_byp = byp_q; n_stat = stat_q; n_cnt = cnt_q;
        prog_o = 1'b0; sect_o = 1'b0; chip_o = 1'b0; abort = 1'b0;
        if (rd_en_i && (cmd_q == CMD_PROG || cmd_q == CMD_CHIP || cmd_q == CMD_SECT))
            n_stat[6] = ~stat_q[6];
        if (ph_q == PH_BUSY) begin
            if (cnt_q > CNT_W'(1)) n_cnt = cnt_q - CNT_W'(1);
            else begin
                n_cnt     = '0;
                n_stat[7] = ~n_stat[7];
                n_ph      = byp_q ? PH_CMD : PH_IDLE;
                n_cmd     = CMD_NONE;
            end
        end
        if (wr_en_i) begin
            if (wdata_i == OP_ABORT && !(ph_q == PH_ARG && cmd_q == CMD_PROG)) abort = 1'b1;
            else begin
                case (ph_q)
                    PH_IDLE: begin
                        if (hit_query) begin n_ph = PH_QUERY; n_cmd = CMD_CFI; end
                        else if (hit_a) n_ph = PH_UNLK;
                        else abort = 1'b1;
                    end
                    PH_UNLK: begin
                        if (hit_b) n_ph = PH_CMD; else abort = 1'b1;
                    end
                    PH_CMD: begin
                        if (!byp_q && off_i != UNLOCK0) abort = 1'b1;
                        else if (wdata_i == OP_BYPASS) begin
                            n_byp = 1'b1; n_ph = PH_CMD; n_cmd = CMD_NONE;
                        end else if (wdata_i == CMD_ERASE || wdata_i == CMD_ID || wdata_i == CMD_PROG) begin
                            n_cmd = cmd_e'(wdata_i); n_ph = PH_ARG;
                        end else abort = 1'b1;
                    end
                    PH_ARG: begin
                        case (cmd_q)
                            CMD_ERASE: begin
                                if (hit_query) begin n_ph = PH_QUERY; n_cmd = CMD_CFI; end
                                else if (hit_a) n_ph = PH_UNLK2;
                                else abort = 1'b1;
                            end
                            CMD_PROG: begin
                                prog_o = 1'b1;
                                n_stat = {~wdata_i[7], 7'h7F};
                                if (byp_q) begin n_ph = PH_CMD; n_cmd = CMD_NONE; end
                                else abort = 1'b1;
                            end
                            CMD_ID: begin
                                if (byp_q && wdata_i == OP_BYPEXIT) abort = 1'b1;
                                else if (hit_query) begin n_ph = PH_QUERY; n_cmd = CMD_CFI; end
                                else abort = 1'b1;
                            end
                            default: abort = 1'b1;
                        endcase
                    end
                    PH_UNLK2: begin
                        if (cmd_q == CMD_ERASE && hit_b) n_ph = PH_SEL; else abort = 1'b1;
                    end
                    PH_SEL: begin
                        if (wdata_i == CMD_CHIP && off_i == UNLOCK0) begin
                            chip_o = 1'b1; n_stat = 8'h00; n_cnt = CNT_W'(CHIP_BUSY);
                            n_cmd = CMD_CHIP; n_ph = PH_BUSY;
                        end else if (wdata_i == CMD_SECT) begin
                            sect_o = 1'b1; n_stat = 8'h00; n_cnt = CNT_W'(SECT_BUSY);
                            n_cmd = CMD_SECT; n_ph = PH_BUSY;
                        end else abort = 1'b1;
                    end
                    PH_BUSY: ;
                    default: abort = 1'b1;
                endcase
            end
        end
        if (abort) begin
            n_ph = PH_IDLE; n_cmd = CMD_NONE; n_byp = 1'b0; n_cnt = '0;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE; cmd_q <= CMD_NONE; byp_q <= 1'b0; stat_q <= 8'h00; cnt_q <= '0;
        end else begin
            ph_q <= n_ph; cmd_q <= n_cmd; byp_q <= n_byp; stat_q <= n_stat; cnt_q <= n_cnt;
        end
    end

    assign cmd_o    = cmd_q;
    assign status_o = stat_q;

    // R5
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && wdata_i == OP_ABORT && !(ph_q == PH_ARG && cmd_q == CMD_PROG)
        |=> ph_q == PH_IDLE && !byp_q);
    // R7
    busy_ignores_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_BUSY && cnt_q > CNT_W'(1) && wr_en_i && wdata_i != OP_ABORT
        |=> ph_q == PH_BUSY && cmd_q == $past(cmd_q));
    // R8
    bypass_prog_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_q && ph_q == PH_ARG && cmd_q == CMD_PROG && wr_en_i
        |=> ph_q == PH_CMD && byp_q);
    // R10
    query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_QUERY && wr_en_i |=> ph_q == PH_IDLE);
endmodule

// File: rtl/nor_seq_array.sv
// Byte array with AND-programming, sector fill and whole-array fill.
// Assumes at most one of prog/sect/chip per cycle; ro blocks all updates.
module nor_seq_array #(
    parameter int ADDR_W = 9,
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              prog_i,
    input  logic              sect_i,
    input  logic              chip_i,
    input  logic              ro_i,
    output logic [7:0]        rd_o
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int SECT_LEN = 1 << SECT_W;

    logic [7:0] mem_q [DEPTH];

    // Array update: reset and erase fill with 0xFF, program clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (!ro_i) begin
            if (chip_i) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            end else if (sect_i) begin
                for (int i = 0; i < DEPTH; i++)
                    if ((i / SECT_LEN) == int'(addr_i[ADDR_W-1:SECT_W])) mem_q[i] <= 8'hFF;
            end else if (prog_i) begin
                mem_q[addr_i] <= mem_q[addr_i] & data_i;
            end
        end
    end

    assign rd_o = mem_q[addr_i];

    // R4
    prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i && !ro_i && !chip_i && !sect_i
        |=> mem_q[$past(addr_i)] == ($past(rd_o) & $past(data_i)));
    // R6
    chip_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_i && !ro_i |=> mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF);
    // R11
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ro_i && prog_i |=> mem_q[$past(addr_i)] == $past(rd_o));
endmodule

// File: rtl/nor_seq_rdmux.sv
// Read source select: array, identification bytes, status or query table.
// Assumes the query table is indexed by the low address byte.
module nor_seq_rdmux
    import nor_seq_pkg::*;
#(
    parameter int         ADDR_W = 9,
    parameter int         SECT_W = 8,
    parameter logic [7:0] ID0    = 8'h01,
    parameter logic [7:0] ID1    = 8'h7E,
    parameter logic [7:0] ID2    = 8'hFF,
    parameter logic [7:0] ID3    = 8'h22
) (
    input  cmd_e       cmd_i,
    input  logic [7:0] off_i,
    input  logic [7:0] arr_i,
    input  logic [7:0] status_i,
    output logic [7:0] data_o
);
    localparam int NSECT    = 1 << (ADDR_W - SECT_W);
    localparam int SECT_LEN = 1 << SECT_W;

    // Geometry query table; unlisted offsets read zero.
    function automatic logic [7:0] qrom(input logic [7:0] o);
        case (o)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h02;
            8'h15: return 8'h31;
            8'h1B: return 8'h27;
            8'h1C: return 8'h36;
            8'h1F: return 8'h07;
            8'h21: return 8'h09;
            8'h22: return 8'h0C;
            8'h23: return 8'h01;
            8'h25: return 8'h0A;
            8'h26: return 8'h0D;
            8'h27: return 8'(ADDR_W);
            8'h28: return 8'h02;
            8'h2C: return 8'h01;
            8'h2D: return 8'(NSECT - 1);
            8'h2E: return 8'((NSECT - 1) >> 8);
            8'h2F: return 8'(SECT_LEN >> 8);
            8'h30: return 8'(SECT_LEN >> 16);
            8'h31: return 8'h50;
            8'h32: return 8'h52;
            8'h33: return 8'h49;
            8'h34: return 8'h31;
            8'h35: return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

    // Source select by active command; unknown commands read the array.
    always_comb begin
        case (cmd_i)
            CMD_ID: begin
                case (off_i)
                    8'h00:   data_o = ID0;
                    8'h01:   data_o = ID1;
                    8'h02:   data_o = 8'h00;
                    8'h0E:   data_o = (ID2 == 8'hFF) ? arr_i : ID2;
                    8'h0F:   data_o = (ID3 == 8'hFF) ? arr_i : ID3;
                    default: data_o = arr_i;
                endcase
            end
            CMD_PROG, CMD_CHIP, CMD_SECT: data_o = status_i;
            CMD_CFI: data_o = qrom(off_i);
            default: data_o = arr_i;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
// Top: parallel NOR flash command sequencer with an internal byte array.
// Assumes ADDR_W >= 8 (word offset is addr[7:0]) and CHIP_BUSY >= SECT_BUSY.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int         ADDR_W    = 9,
    parameter int         SECT_W    = 8,
    parameter logic [7:0] UNLOCK0   = 8'hAA,
    parameter logic [7:0] UNLOCK1   = 8'h55,
    parameter logic [7:0] ID0       = 8'h01,
    parameter logic [7:0] ID1       = 8'h7E,
    parameter logic [7:0] ID2       = 8'hFF,
    parameter logic [7:0] ID3       = 8'h22,
    parameter int         SECT_BUSY = 16,
    parameter int         CHIP_BUSY = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ro,
    output logic [7:0]        rd_data
);
    cmd_e       cmd;
    logic [7:0] status, arr_byte, rd_next;
    logic       prog, sect, chip;

    nor_seq_ctrl #(.UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1),
                   .SECT_BUSY(SECT_BUSY), .CHIP_BUSY(CHIP_BUSY)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .off_i(addr[7:0]), .wdata_i(wdata), .cmd_o(cmd), .status_o(status),
        .prog_o(prog), .sect_o(sect), .chip_o(chip)
    );

    nor_seq_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(wdata),
        .prog_i(prog), .sect_i(sect), .chip_i(chip), .ro_i(ro), .rd_o(arr_byte)
    );

    nor_seq_rdmux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W),
                    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_rdmux (
        .cmd_i(cmd), .off_i(addr[7:0]), .arr_i(arr_byte),
        .status_i(status), .data_o(rd_next)
    );

    // Registered read port: captures the selected source on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
    localparam int AW = 9;
    localparam int DEPTH = 1 << AW;
    localparam logic [7:0] U0 = 8'hAA, U1 = 8'h55;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ro = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, rd_data;
    logic [7:0] ref_mem [DEPTH];
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    nor_cmd_seq u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                       .addr(addr), .wdata(wdata), .ro(ro), .rd_data(rd_data));

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ (a >> 3));
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; v = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic unlock();
        wr({1'b0, U0}, 8'hAA);
        wr({1'b0, U1}, 8'h55);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        unlock(); wr({1'b0, U0}, 8'hA0); wr(a, d);
    endtask

    task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] op);
        unlock(); wr({1'b0, U0}, 8'h80); unlock(); wr(a, op);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_data after reset", rd_data, 8'h00);
        rd_chk("R1 array erased", 9'h000, 8'hFF);
        rd_chk("R1 array erased", 9'h1FF, 8'hFF);
        rd_chk("R1 array erased", 9'h055, 8'hFF);

        // R8: bypass sweep, program every byte without unlock pairs
        unlock(); wr({1'b0, U0}, 8'h20);
        for (int a = 0; a < DEPTH; a++) begin
            wr(9'((a * 7) ^ 9'h0C3), 8'hA0);
            wr(9'(a), pat(a));
            ref_mem[a] = ref_mem[a] & pat(a);
        end
        wr(9'h000, 8'hF0);
        // R4: sweep readback
        for (int a = 0; a < DEPTH; a++) rd_chk("R4 sweep program", 9'(a), ref_mem[a]);

        // R5: bypass cleared by 0xF0, program without unlock has no effect
        wr(9'h020, 8'hA0); wr(9'h020, 8'h00);
        rd_chk("R5 bypass cleared", 9'h020, ref_mem[32]);
        // R5: abort in command slot
        unlock(); wr({1'b0, U0}, 8'hF0); wr({1'b0, U0}, 8'hA0); wr(9'h021, 8'h00);
        rd_chk("R5 abort in slot", 9'h021, ref_mem[33]);

        // R4: AND programming and 0xF0 as data
        program_byte(9'h010, 8'h0F); ref_mem[16] = ref_mem[16] & 8'h0F;
        program_byte(9'h011, 8'hF0); ref_mem[17] = ref_mem[17] & 8'hF0;
        rd_chk("R4 and program", 9'h010, ref_mem[16]);
        rd_chk("R4 F0 as data", 9'h011, ref_mem[17]);
        rd_chk("R4 back to read", 9'h012, ref_mem[18]);

        // R2: second unlock write at wrong offset
        wr({1'b0, U0}, 8'hAA); wr(9'h033, 8'h55); wr({1'b0, U0}, 8'hA0); wr(9'h013, 8'h00);
        rd_chk("R2 bad unlock offset", 9'h013, ref_mem[19]);
        // R2: command at wrong offset
        unlock(); wr(9'h001, 8'hA0); wr(9'h014, 8'h00);
        rd_chk("R2 bad command offset", 9'h014, ref_mem[20]);
        // R3: unknown command byte
        unlock(); wr({1'b0, U0}, 8'h33); wr(9'h015, 8'h00);
        rd_chk("R3 unknown command", 9'h015, ref_mem[21]);

        // R9: identification reads
        unlock(); wr({1'b0, U0}, 8'h90);
        rd_chk("R9 id0", 9'h000, 8'h01);
        rd_chk("R9 id1", 9'h001, 8'h7E);
        rd_chk("R9 protect", 9'h002, 8'h00);
        rd_chk("R9 id2 fallback", 9'h00E, ref_mem[14]);
        rd_chk("R9 id3", 9'h00F, 8'h22);
        rd_chk("R9 other offset", 9'h005, ref_mem[5]);
        // R10: query mode from identification
        wr(9'h055, 8'h98);
        rd_chk("R10 query from id", 9'h010, 8'h51);
        wr(9'h000, 8'h12);
        rd_chk("R10 exit query", 9'h010, ref_mem[16]);

        // R10: query mode from read mode
        wr(9'h055, 8'h98);
        rd_chk("R10 Q", 9'h010, 8'h51);
        rd_chk("R10 R", 9'h011, 8'h52);
        rd_chk("R10 Y", 9'h012, 8'h59);
        rd_chk("R10 size", 9'h027, 8'd9);
        rd_chk("R10 sectors", 9'h02D, 8'd1);
        rd_chk("R10 sector size", 9'h02F, 8'd1);
        rd_chk("R10 past end", 9'h052, 8'h00);
        rd_chk("R10 past end", 9'h060, 8'h00);
        wr(9'h000, 8'h00);
        rd_chk("R10 write exits", 9'h027, ref_mem[39]);

        // R6/R7: sector erase with busy window
        erase_seq(9'h105, 8'h30);
        for (int a = 256; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        rd_chk("R7 status first", 9'h105, 8'h00);
        rd_chk("R7 status toggle", 9'h105, 8'h40);
        wr(9'h100, 8'hAA);
        rd_chk("R7 write ignored", 9'h000, 8'h00);
        idle(20);
        for (int a = 0; a < DEPTH; a++) rd_chk("R6 sector erase", 9'(a), ref_mem[a]);

        // R6: chip erase at wrong offset aborts
        erase_seq(9'h033, 8'h10);
        rd_chk("R6 chip erase bad offset", 9'h010, ref_mem[16]);
        // R5: chip erase, abort during busy window
        erase_seq({1'b0, U0}, 8'h10);
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        rd_chk("R7 chip status", 9'h000, 8'h00);
        wr(9'h000, 8'hF0);
        for (int a = 0; a < DEPTH; a += 17) rd_chk("R6 chip erase", 9'(a), 8'hFF);

        // R8: bypass identification then 0x00 exit
        unlock(); wr({1'b0, U0}, 8'h20);
        wr(9'h077, 8'h90);
        rd_chk("R8 bypass id", 9'h000, 8'h01);
        wr(9'h077, 8'h00);
        wr(9'h030, 8'hA0); wr(9'h030, 8'h00);
        rd_chk("R8 bypass exit", 9'h030, 8'hFF);
        // R7: erase in bypass returns to command slot
        unlock(); wr({1'b0, U0}, 8'h20);
        wr(9'h077, 8'h80); unlock(); wr(9'h100, 8'h30);
        idle(20);
        wr(9'h0F1, 8'hA0); wr(9'h101, 8'h12); ref_mem[257] = 8'h12;
        wr(9'h000, 8'hF0);
        rd_chk("R7 bypass after erase", 9'h101, 8'h12);

        // R11: read-only input
        ro = 1'b1;
        program_byte(9'h040, 8'h00);
        rd_chk("R11 ro program", 9'h040, 8'hFF);
        ro = 1'b0;
        program_byte(9'h040, 8'h3C);
        rd_chk("R11 protocol intact", 9'h040, 8'h3C);
        ro = 1'b1;
        erase_seq(9'h040, 8'h30);
        rd_chk("R11 ro erase status", 9'h040, 8'h00);
        idle(20);
        ro = 1'b0;
        rd_chk("R11 ro erase", 9'h040, 8'h3C);
        rd_chk("R11 ro erase", 9'h101, 8'h12);

        // R12: rd_data holds without a read strobe
        v = rd_data;
        wr(9'h000, 8'h00);
        idle(3);
        chk("R12 hold", rd_data, v);

        finish_run();
    end
endmodule